// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects interrupt requests from a bank of eight software-settable sources and a parameterised set of peripheral lines. Every source has its own 4-bit priority, and level 0 disables the source. The block picks one winner among the pending sources and raises a single request to the processor. It does so only when the winner's priority is strictly above the live current-priority value and the nesting stack still has room.

When the processor acknowledges, the block does three things. It clears the winner's pending flag, pushes the current priority onto a LIFO and loads the winner's priority as the new current priority. A write to the end-of-interrupt register pops the LIFO and restores the level that was active before the interrupt was taken. Software may also write the current priority directly. This lets it raise the level to the ceiling of every handler that shares a resource, so that only sources above that ceiling can still preempt. It can then read the value back before it touches the shared data.

Top module: `prio_intc`

## Requirements
- R1: `irqReq` is high exactly when some pending source has a nonzero priority greater than the current priority and the stack is not full. A source whose priority is 0, or not above the current priority, never raises it.
- R2: Among eligible pending sources, the one with the highest priority wins. When priorities are equal, the lowest vector wins. `irqVector` shows the winner.
- R3: Software source k (0..7) uses vector k. Peripheral line n uses vector n+8 and becomes pending on a rising edge of `periphReq[n]`.
- R4: A write to address 2 sets software pending flags with bits [7:0] and clears them with bits [15:8]. Set wins over clear in the same write. A read of address 2 returns the software pending flags in bits [7:0].
- R5: An acknowledge (`ackIn` high while `irqReq` is high) clears the winner's pending flag, pushes the current priority and loads the winner's priority as the current priority.
- R6: A write to address 0 loads the current priority from bits [3:0]. From the next cycle, the request decision compares against the new value. A read of address 0 returns the live current priority in bits [3:0].
- R7: Any write to address 1 (end of interrupt) pops the stack into the current priority. With an empty stack it is ignored and the current priority stays unchanged.
- R8: Nested acknowledges unwind in LIFO order through successive end-of-interrupt writes.
- R9: While the stack holds STACK_DEPTH entries, no request is raised. After a pop, requests resume.
- R10: A write to address 0 or address 1 in the same cycle as an acknowledge is discarded, and the acknowledge alone updates the current priority and the stack.
- R11: The priority of vector v is written and read at address 2^(ADDR_W-1)+v, bits [3:0]. All priorities reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational on regAddr) |
| periphReq | input | NUM_PERIPH | Peripheral request lines, rising-edge sensitive |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVector | output | $clog2(8+NUM_PERIPH) | Vector of the winning source |
| ackIn | input | 1 | Processor acknowledge |

## Verification
The bench builds the block with eight peripheral lines and a four-entry stack, which gives sixteen vectors in total. With that size, every combination of source vector, source priority and current priority can be swept in full, 4096 cases. In each case the request decision and the vector are compared against a bench-side calculation. The small stack makes the full-stack blocking and resume case reachable after only four nested acknowledges. All sixteen sources pending together allow the complete tie-break service order to be predicted and checked.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int SW_SRC = 8;
  localparam int PRIO_W = 4;
  localparam int REG_W  = 16;

  localparam int ADDR_CPR   = 0;
  localparam int ADDR_EOI   = 1;
  localparam int ADDR_SWCTL = 2;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic              ack;
    logic              cprWr;
    logic              eoiWr;
    logic              prioWr;
    logic [SW_SRC-1:0] swSet;
    logic [SW_SRC-1:0] swClr;
  } ctrl_strobes_t;
endpackage

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int VEC_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pending,
  input  prio_t              prioArr [NUM_SRC],
  output logic               found,
  output logic [VEC_W-1:0]   winVec,
  output prio_t              winPrio
);
  // Scan from the top vector down; ">=" lets a lower vector take over a tie.
  always_comb begin
    found   = 1'b0;
    winVec  = '0;
    winPrio = '0;
    for (int v = NUM_SRC - 1; v >= 0; v--) begin
      if (pending[v] && (prioArr[v] != '0) && (prioArr[v] >= winPrio)) begin
        found   = 1'b1;
        winPrio = prioArr[v];
        winVec  = VEC_W'(v);
      end
    end
  end
endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              ackIn,
  input  logic              irqReq,
  output ctrl_strobes_t     strobes
);
  logic ackTaken;
  logic hitCpr, hitEoi, hitSw;

  always_comb begin
    ackTaken = ackIn && irqReq;
    hitCpr   = regWrEn && (regAddr == ADDR_W'(ADDR_CPR));
    hitEoi   = regWrEn && (regAddr == ADDR_W'(ADDR_EOI));
    hitSw    = regWrEn && (regAddr == ADDR_W'(ADDR_SWCTL));

    strobes.ack    = ackTaken;
    // An acknowledge owns the priority/stack path; a colliding write is dropped.
    strobes.cprWr  = hitCpr && !ackTaken;
    strobes.eoiWr  = hitEoi && !ackTaken;
    strobes.prioWr = regWrEn && regAddr[ADDR_W-1];
    strobes.swSet  = hitSw ? regWdata[SW_SRC-1:0] : '0;
    strobes.swClr  = hitSw ? regWdata[2*SW_SRC-1:SW_SRC] : '0;
  end
endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NUM_PERIPH  = 8,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 6,
  localparam int NUM_SRC = SW_SRC + NUM_PERIPH,
  localparam int VEC_W   = $clog2(NUM_SRC),
  localparam int SP_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobes_t         strobes,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWdata,
  input  logic [NUM_PERIPH-1:0] periphReq,
  output logic [REG_W-1:0]      regRdata,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVector,
  output prio_t                 curPrioOut,
  output prio_t                 winPrioOut,
  output logic [SP_W-1:0]       stackDepthOut
);
  localparam int IDX_W  = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int LOWA_W = ADDR_W - 1;

  prio_t                 prioReg [NUM_SRC];
  logic [NUM_SRC-1:0]    pending, pendNext;
  logic [NUM_PERIPH-1:0] periphPrev;
  prio_t                 curPrio;
  prio_t                 stackMem [STACK_DEPTH];
  logic [SP_W-1:0]       sp, spDec;
  logic [IDX_W-1:0]      pushIdx, popIdx;
  logic                  stackFull, stackEmpty;
  logic                  found;
  logic [VEC_W-1:0]      winVec;
  prio_t                 winPrio;

  prio_intc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pending (pending),
    .prioArr (prioReg),
    .found   (found),
    .winVec  (winVec),
    .winPrio (winPrio)
  );

  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign spDec      = sp - SP_W'(1);
  assign pushIdx    = IDX_W'(sp);
  assign popIdx     = IDX_W'(spDec);

  assign irqReq    = found && (winPrio > curPrio) && !stackFull;
  assign irqVector = winVec;

  // Pending next-state: set sources dominate clears and acknowledge.
  for (genvar v = 0; v < NUM_SRC; v++) begin : g_pend
    logic clrAck;
    assign clrAck = strobes.ack && (winVec == VEC_W'(v));
    if (v < SW_SRC) begin : g_sw
      assign pendNext[v] = (pending[v] & ~clrAck & ~strobes.swClr[v]) | strobes.swSet[v];
    end else begin : g_per
      assign pendNext[v] = (pending[v] & ~clrAck)
                         | (periphReq[v-SW_SRC] & ~periphPrev[v-SW_SRC]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioReg[v] <= '0;
      end else if (strobes.prioWr && (regAddr[LOWA_W-1:0] == LOWA_W'(v))) begin
        prioReg[v] <= regWdata[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= '0;
      periphPrev <= '0;
    end else begin
      pending    <= pendNext;
      periphPrev <= periphReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPrio <= '0;
      sp      <= '0;
    end else if (strobes.ack) begin
      curPrio <= winPrio;
      sp      <= sp + SP_W'(1);
    end else if (strobes.cprWr) begin
      curPrio <= regWdata[PRIO_W-1:0];
    end else if (strobes.eoiWr && !stackEmpty) begin
      curPrio <= stackMem[popIdx];
      sp      <= spDec;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.ack) begin
      stackMem[pushIdx] <= curPrio;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr[ADDR_W-1]) begin
      for (int v = 0; v < NUM_SRC; v++) begin
        if (regAddr[LOWA_W-1:0] == LOWA_W'(v)) begin
          regRdata[PRIO_W-1:0] = prioReg[v];
        end
      end
    end else if (regAddr == ADDR_W'(ADDR_CPR)) begin
      regRdata[PRIO_W-1:0] = curPrio;
    end else if (regAddr == ADDR_W'(ADDR_SWCTL)) begin
      regRdata[SW_SRC-1:0] = pending[SW_SRC-1:0];
    end
  end

  assign curPrioOut    = curPrio;
  assign winPrioOut    = winPrio;
  assign stackDepthOut = sp;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_PERIPH  = 8,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 6,
  localparam int NUM_SRC = SW_SRC + NUM_PERIPH,
  localparam int VEC_W   = $clog2(NUM_SRC),
  localparam int SP_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [15:0]           regWdata,
  output logic [15:0]           regRdata,
  input  logic [NUM_PERIPH-1:0] periphReq,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVector,
  input  logic                  ackIn
);
  ctrl_strobes_t   strobes;
  prio_t           curPrio;
  prio_t           winPrio;
  logic [SP_W-1:0] stackDepth;

  prio_intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .ackIn    (ackIn),
    .irqReq   (irqReq),
    .strobes  (strobes)
  );

  prio_intc_dp #(
    .NUM_PERIPH  (NUM_PERIPH),
    .STACK_DEPTH (STACK_DEPTH),
    .ADDR_W      (ADDR_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .regAddr       (regAddr),
    .regWdata      (regWdata),
    .periphReq     (periphReq),
    .regRdata      (regRdata),
    .irqReq        (irqReq),
    .irqVector     (irqVector),
    .curPrioOut    (curPrio),
    .winPrioOut    (winPrio),
    .stackDepthOut (stackDepth)
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 6,
  localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              ackIn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [15:0]       regWdata,
  input prio_t             curPrio,
  input prio_t             winPrio,
  input logic [SP_W-1:0]   stackDepth
);
  logic ackSeen, cprHit, eoiHit;
  assign ackSeen = ackIn && irqReq;
  assign cprHit  = regWrEn && (regAddr == ADDR_W'(ADDR_CPR));
  assign eoiHit  = regWrEn && (regAddr == ADDR_W'(ADDR_EOI));

  p_ack_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackSeen |=> (curPrio == $past(winPrio)) && (stackDepth == $past(stackDepth) + SP_W'(1)));

  p_cpr_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cprHit && !ackSeen) |=> (curPrio == $past(regWdata[PRIO_W-1:0])));

  p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (eoiHit && !ackSeen && stackDepth == '0) |=> ($stable(curPrio) && stackDepth == '0));

  p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eoiHit && !ackSeen && stackDepth != '0) |=> (stackDepth == $past(stackDepth) - SP_W'(1)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= SP_W'(STACK_DEPTH));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stackDepth == SP_W'(STACK_DEPTH)) |-> !irqReq);

  p_ack_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cprHit && ackSeen) |=> (curPrio == $past(winPrio)));
endmodule

bind prio_intc prio_intc_chk #(
  .STACK_DEPTH (STACK_DEPTH),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .irqReq     (irqReq),
  .ackIn      (ackIn),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .curPrio    (curPrio),
  .winPrio    (winPrio),
  .stackDepth (stackDepth)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  localparam int NP = 8;
  localparam int SD = 4;
  localparam int AW = 6;
  localparam int NS = 8 + NP;
  localparam int PB = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic [NP-1:0] periphReq = '0;
  logic          irqReq;
  logic [3:0]    irqVector;
  logic          ackIn = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_intc #(.NUM_PERIPH(NP), .STACK_DEPTH(SD), .ADDR_W(AW)) i_prio_intc (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .periphReq(periphReq),
    .irqReq(irqReq), .irqVector(irqVector), .ackIn(ackIn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input int a, input int d);
    regWrEn = 1'b1; regAddr = AW'(a); regWdata = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    regAddr = AW'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic doAck();
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
  endtask

  task automatic trigger(input int v);
    if (v < 8) begin
      wr(2, 1 << v);
    end else begin
      periphReq[v-8] = 1'b1;
      @(negedge clk);
      periphReq[v-8] = 1'b0;
    end
  endtask

  initial begin
    int rv;
    int prio [NS];
    int pend [NS];
    int best, bv, expP;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R1 reset irqReq", int'(irqReq), 0);
    rd(0, rv); chk("R6 reset current priority", rv, 0);
    rd(PB + 5, rv); chk("R11 reset priority", rv, 0);

    // R11 priority readback, upper bits dropped
    wr(PB + 1, 16'h001F); rd(PB + 1, rv); chk("R11 priority readback", rv, 15);
    wr(PB + 1, 0);

    // R4 software set/clear
    wr(PB + 3, 7);
    wr(2, 1 << 3); rd(2, rv); chk("R4 set", rv, 8);
    chk("R4 request after set", int'(irqReq), 1);
    wr(2, 1 << 11); rd(2, rv); chk("R4 clear", rv, 0);
    chk("R4 no request after clear", int'(irqReq), 0);
    wr(2, (1 << 3) | (1 << 11)); rd(2, rv); chk("R4 set dominates clear", rv, 8);
    wr(2, 1 << 11); wr(PB + 3, 0);

    // R7 end of interrupt with empty stack
    wr(0, 5); wr(1, 0); rd(0, rv); chk("R7 empty pop ignored", rv, 5);
    wr(0, 0);

    // Full sweep: vector x priority x current priority (R1, R3, R5, R6, R7)
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        for (int v = 0; v < NS; v++) begin
          wr(PB + v, p);
          wr(0, c);
          trigger(v);
          chk("R1 request vs current priority", int'(irqReq), (p > c) ? 1 : 0);
          if (p > c) chk("R3 vector mapping", int'(irqVector), v);
          wr(0, 0);
          if (p == 0) wr(PB + v, 1);
          chk("R1 request at level zero", int'(irqReq), 1);
          doAck();
          rd(0, rv); chk("R5 ack loads priority", rv, (p == 0) ? 1 : p);
          wr(1, 0);
          rd(0, rv); chk("R7 pop restores", rv, 0);
          wr(PB + v, 0);
        end
      end
    end

    // R2 service order with every source pending
    for (int v = 0; v < NS; v++) begin
      prio[v] = 1 + (v * 3) % 5;
      pend[v] = 1;
      wr(PB + v, prio[v]);
    end
    wr(2, 16'h00FF);
    periphReq = '1; @(negedge clk); periphReq = '0;
    for (int k = 0; k < NS; k++) begin
      best = 0; bv = 0;
      for (int v = NS - 1; v >= 0; v--) begin
        if (pend[v] == 1 && prio[v] >= best) begin best = prio[v]; bv = v; end
      end
      chk("R2 winner vector", int'(irqVector), bv);
      doAck();
      pend[bv] = 0;
      rd(0, rv); chk("R2 winner priority", rv, best);
      chk("R1 equal levels blocked", int'(irqReq), 0);
      wr(1, 0);
    end
    for (int v = 0; v < NS; v++) wr(PB + v, 0);

    // R8/R9 nesting and full stack
    for (int v = 0; v < 5; v++) wr(PB + v, 2 * (v + 1));
    for (int v = 0; v < 4; v++) begin
      trigger(v);
      chk("R8 nested request", int'(irqReq), 1);
      doAck();
      rd(0, rv); chk("R8 nested level", rv, 2 * (v + 1));
    end
    trigger(4);
    chk("R9 full stack blocks", int'(irqReq), 0);
    wr(1, 0);
    chk("R9 resume after pop", int'(irqReq), 1);
    chk("R9 resume vector", int'(irqVector), 4);
    doAck();
    rd(0, rv); chk("R8 preempt level", rv, 10);
    for (int k = 3; k >= 0; k--) begin
      wr(1, 0);
      rd(0, rv);
      expP = 2 * k;
      chk("R8 LIFO unwind", rv, (k == 3) ? 6 : expP + 2 - 2);
    end
    wr(1, 0); rd(0, rv); chk("R7 pop after unwind", rv, 0);
    wr(1, 0); rd(0, rv); chk("R7 empty stack ignored", rv, 0);
    for (int v = 0; v < 5; v++) wr(PB + v, 0);

    // R6 elevation in the same cycle as a new peripheral request
    wr(PB + 8, 6);
    regWrEn = 1'b1; regAddr = AW'(0); regWdata = 16'd9; periphReq[0] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; periphReq[0] = 1'b0;
    chk("R6 elevation blocks same-cycle request", int'(irqReq), 0);
    rd(0, rv); chk("R6 live readback", rv, 9);
    wr(0, 5);
    chk("R6 request after lowering", int'(irqReq), 1);
    chk("R3 peripheral vector", int'(irqVector), 8);

    // R10 write colliding with acknowledge
    regWrEn = 1'b1; regAddr = AW'(0); regWdata = 16'd3; ackIn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; ackIn = 1'b0;
    rd(0, rv); chk("R10 ack beats priority write", rv, 6);
    wr(1, 0); rd(0, rv); chk("R10 pushed value", rv, 5);
    wr(PB + 2, 9); trigger(2);
    regWrEn = 1'b1; regAddr = AW'(1); regWdata = 16'd0; ackIn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; ackIn = 1'b0;
    rd(0, rv); chk("R10 ack beats end of interrupt", rv, 9);
    wr(1, 0); rd(0, rv); chk("R10 single pop", rv, 5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule